// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits at the head of a receive path and looks at the first six bytes of every incoming frame, which form the destination address. It gathers those bytes and builds a hash of them as they arrive. It compares the address against a programmed station address and checks the group bit and the all-ones pattern. It then produces one accept decision together with four classification flags. The receive logic further down uses the decision to keep or drop the frame, and copies the flags into the frame's status word.

Three configuration inputs control filtering: a 48-bit station address, a 64-bit multicast hash mask and a 2-bit mode. The hash index is the top six bits of a CRC-32 computed over the address. That index selects one bit of the mask, which decides whether a multicast frame is wanted. The block takes a snapshot of the configuration when a frame starts, so software can rewrite it at any time without corrupting a frame already in progress.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset, outValid, outAccept, every flag and outStatusFlags are 0.
- R2: outStationHit is 1 exactly when the six address bytes equal cfgStation, where the first received byte is compared with cfgStation[47:40] and the sixth with cfgStation[7:0].
- R3: outMulticast is 1 when bit 0 of the first address byte is 1. outBroadcast is 1 when all 48 address bits are 1. A broadcast frame is therefore also flagged multicast.
- R4: The hash index is bits 31:26 of a CRC-32 with polynomial 0x04C11DB7. The CRC register is preset to all ones and is not inverted at the end. It shifts toward its most significant bit, and each byte is fed bit 0 first. outHashHit is 1 when the frame is multicast and cfgHashMask[index] is 1.
- R5: The mode decides acceptance in addition to the cases in R6. Mode 00 accepts only the cases in R6. Mode 01 also accepts multicast frames whose hash bit is set. Mode 10 also accepts every multicast frame. Mode 11 accepts every frame.
- R6: A frame that is broadcast or that matches the station address is accepted in every mode.
- R7: A byte is taken when inValid is 1. Let edge k be the clock edge that takes the sixth address byte. outValid stays 0 after edge k and becomes 1 after edge k+1. A taken byte with inSof set clears outValid, outAccept and all flags at its edge.
- R8: Once valid, the decision and flags hold until the next taken start byte. The block ignores all of the following: bytes after the sixth, cycles with inValid 0 (even when inSof is 1), and any bytes taken before the first start byte.
- R9: The block samples cfgStation, cfgHashMask and cfgMode at the edge that takes the start byte. Changes made during a frame affect only later frames.
- R10: outStatusFlags carries the multicast flag at bit 19, broadcast at bit 20, hash match at bit 25 and station match at bit 26. All its other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgStation | input | 48 | Station address, first received byte in bits 47:40 |
| cfgHashMask | input | 64 | Multicast hash mask, one bit per hash index |
| cfgMode | input | 2 | Filter mode: 00 station, 01 hashed multicast, 10 all multicast, 11 promiscuous |
| inSof | input | 1 | Marks the taken byte as the first byte of a frame |
| inValid | input | 1 | Byte on inByte is taken this cycle |
| inByte | input | 8 | Received byte |
| outValid | output | 1 | Decision and flags are valid |
| outAccept | output | 1 | Frame is accepted |
| outMulticast | output | 1 | Group bit set |
| outBroadcast | output | 1 | All-ones destination |
| outStationHit | output | 1 | Destination equals station address |
| outHashHit | output | 1 | Multicast with its hash mask bit set |
| outStatusFlags | output | 32 | Flags at their receive status word positions |

## Verification
The bench sweeps all four modes against three masks: empty, full and random. Each combination gets the station address, a one-bit-off station address, broadcast, and pseudo-random unicast and multicast addresses. These cases separate station-driven, broadcast-driven and mode-driven acceptance. A sweep over all 64 hash indices programs a single mask bit and sends one address that hashes to that bit and one that does not. This pins the CRC bit order and the choice of index bits. Frames with idle gaps, with a start marker raised while no byte is taken, with trailing payload, and with configuration changed mid-address show whether counting, holding and the configuration snapshot behave as required.

// File: rtl/rx_dest_filter_pkg.sv
`timescale 1ns/1ps
package rx_dest_filter_pkg;

  localparam int FLAG_MC_POS  = 19;
  localparam int FLAG_BC_POS  = 20;
  localparam int FLAG_HH_POS  = 25;
  localparam int FLAG_SH_POS  = 26;
  localparam int STATUS_WIDTH = 32;

  typedef enum logic [1:0] {
    MODE_STATION = 2'b00,
    MODE_HASHED  = 2'b01,
    MODE_ALLMC   = 2'b10,
    MODE_PROMISC = 2'b11
  } fltMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic start;   // first byte of a frame taken
    logic shift;   // an address byte is taken
    logic decide;  // register the decision
  } fltStrobe_t;

  // One byte of a big-endian CRC, bit 0 of the byte first
  function automatic logic [31:0] crcStep(input logic [31:0] crcIn,
                                          input logic [7:0]  dataIn,
                                          input logic [31:0] poly);
    logic [31:0] c;
    logic        fb;
    c = crcIn;
    for (int i = 0; i < 8; i++) begin
      fb = c[31] ^ dataIn[i];
      c  = {c[30:0], 1'b0} ^ (fb ? poly : 32'h0);
    end
    return c;
  endfunction

endpackage

// File: rtl/rx_dest_filter_ctrl.sv
`timescale 1ns/1ps
module rx_dest_filter_ctrl
  import rx_dest_filter_pkg::*;
#(
  parameter int ADDR_BYTES = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inSof,
  input  logic       inValid,
  output fltStrobe_t strobe
);
  localparam int CW = $clog2(ADDR_BYTES + 1);

  logic [CW-1:0] byteCnt;   // 0: no frame seen, ADDR_BYTES: address complete
  logic          pending;
  logic          sofNow;
  logic          inAddr;
  logic          shiftNow;
  logic          lastNow;

  assign sofNow   = inSof & inValid;
  assign inAddr   = (byteCnt != '0) && (byteCnt < CW'(ADDR_BYTES));
  assign shiftNow = sofNow | (inValid & inAddr);
  assign lastNow  = shiftNow & (sofNow ? (ADDR_BYTES == 1)
                                       : (byteCnt == CW'(ADDR_BYTES - 1)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteCnt <= '0;
      pending <= 1'b0;
    end else begin
      if (sofNow)        byteCnt <= CW'(1);
      else if (shiftNow) byteCnt <= byteCnt + CW'(1);
      pending <= lastNow;
    end
  end

  assign strobe.start  = sofNow;
  assign strobe.shift  = shiftNow;
  assign strobe.decide = pending & ~sofNow;

endmodule

// File: rtl/rx_dest_filter_dp.sv
`timescale 1ns/1ps
module rx_dest_filter_dp
  import rx_dest_filter_pkg::*;
#(
  parameter int          ADDR_BYTES = 6,
  parameter int          HASH_BITS  = 6,
  parameter logic [31:0] CRC_POLY   = 32'h04C11DB7
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  fltStrobe_t                  strobe,
  input  logic [7:0]                  inByte,
  input  logic [8*ADDR_BYTES-1:0]     cfgStation,
  input  logic [(1<<HASH_BITS)-1:0]   cfgHashMask,
  input  logic [1:0]                  cfgMode,
  output logic                        outValid,
  output logic                        outAccept,
  output logic                        outMulticast,
  output logic                        outBroadcast,
  output logic                        outStationHit,
  output logic                        outHashHit
);
  localparam int AW = 8 * ADDR_BYTES;
  localparam int MW = 1 << HASH_BITS;

  logic [AW-1:0]        stationQ;
  logic [MW-1:0]        maskQ;
  fltMode_e             modeQ;
  logic [AW-1:0]        addrQ;
  logic [31:0]          crcQ;

  logic [HASH_BITS-1:0] hashIdx;
  logic                 isMc;
  logic                 isBc;
  logic                 stHit;
  logic                 hHit;
  logic                 acceptNow;

  assign hashIdx = crcQ[31 -: HASH_BITS];
  assign isMc    = addrQ[AW-8];
  assign isBc    = &addrQ;
  assign stHit   = (addrQ == stationQ);
  assign hHit    = isMc & maskQ[hashIdx];

  always_comb begin
    acceptNow = isBc | stHit;
    unique case (modeQ)
      MODE_STATION: acceptNow = acceptNow;
      MODE_HASHED:  acceptNow = acceptNow | hHit;
      MODE_ALLMC:   acceptNow = acceptNow | isMc;
      MODE_PROMISC: acceptNow = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stationQ      <= '0;
      maskQ         <= '0;
      modeQ         <= MODE_STATION;
      addrQ         <= '0;
      crcQ          <= '1;
      outValid      <= 1'b0;
      outAccept     <= 1'b0;
      outMulticast  <= 1'b0;
      outBroadcast  <= 1'b0;
      outStationHit <= 1'b0;
      outHashHit    <= 1'b0;
    end else if (strobe.start) begin
      stationQ      <= cfgStation;
      maskQ         <= cfgHashMask;
      modeQ         <= fltMode_e'(cfgMode);
      addrQ         <= {{(AW-8){1'b0}}, inByte};
      crcQ          <= crcStep(32'hFFFF_FFFF, inByte, CRC_POLY);
      outValid      <= 1'b0;
      outAccept     <= 1'b0;
      outMulticast  <= 1'b0;
      outBroadcast  <= 1'b0;
      outStationHit <= 1'b0;
      outHashHit    <= 1'b0;
    end else begin
      if (strobe.shift) begin
        addrQ <= {addrQ[AW-9:0], inByte};
        crcQ  <= crcStep(crcQ, inByte, CRC_POLY);
      end
      if (strobe.decide) begin
        outValid      <= 1'b1;
        outAccept     <= acceptNow;
        outMulticast  <= isMc;
        outBroadcast  <= isBc;
        outStationHit <= stHit;
        outHashHit    <= hHit;
      end
    end
  end

endmodule

// File: rtl/rx_dest_filter.sv
`timescale 1ns/1ps
module rx_dest_filter
  import rx_dest_filter_pkg::*;
#(
  parameter int          ADDR_BYTES = 6,
  parameter int          HASH_BITS  = 6,
  parameter logic [31:0] CRC_POLY   = 32'h04C11DB7
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [8*ADDR_BYTES-1:0]     cfgStation,
  input  logic [(1<<HASH_BITS)-1:0]   cfgHashMask,
  input  logic [1:0]                  cfgMode,
  input  logic                        inSof,
  input  logic                        inValid,
  input  logic [7:0]                  inByte,
  output logic                        outValid,
  output logic                        outAccept,
  output logic                        outMulticast,
  output logic                        outBroadcast,
  output logic                        outStationHit,
  output logic                        outHashHit,
  output logic [STATUS_WIDTH-1:0]     outStatusFlags
);
  fltStrobe_t strobe;

  rx_dest_filter_ctrl #(.ADDR_BYTES(ADDR_BYTES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inSof   (inSof),
    .inValid (inValid),
    .strobe  (strobe)
  );

  rx_dest_filter_dp #(
    .ADDR_BYTES (ADDR_BYTES),
    .HASH_BITS  (HASH_BITS),
    .CRC_POLY   (CRC_POLY)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .inByte        (inByte),
    .cfgStation    (cfgStation),
    .cfgHashMask   (cfgHashMask),
    .cfgMode       (cfgMode),
    .outValid      (outValid),
    .outAccept     (outAccept),
    .outMulticast  (outMulticast),
    .outBroadcast  (outBroadcast),
    .outStationHit (outStationHit),
    .outHashHit    (outHashHit)
  );

  always_comb begin
    outStatusFlags              = '0;
    outStatusFlags[FLAG_MC_POS] = outMulticast;
    outStatusFlags[FLAG_BC_POS] = outBroadcast;
    outStatusFlags[FLAG_HH_POS] = outHashHit;
    outStatusFlags[FLAG_SH_POS] = outStationHit;
  end

endmodule

// File: rtl/rx_dest_filter_chk.sv
`timescale 1ns/1ps
module rx_dest_filter_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inSof,
  input logic        inValid,
  input logic        outValid,
  input logic        outAccept,
  input logic        outMulticast,
  input logic        outBroadcast,
  input logic        outStationHit,
  input logic        outHashHit,
  input logic [31:0] outStatusFlags
);

  AST_SOF_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (inSof && inValid) |=> !outValid); // R7

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !(inSof && inValid)) |=>
      (outValid && $stable(outAccept) && $stable(outStatusFlags))); // R8

  AST_BCAST_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outBroadcast) |-> (outAccept && outMulticast)); // R6

  AST_STATION_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outStationHit) |-> outAccept); // R6

  AST_HASH_NEEDS_MC: assert property (@(posedge clk) disable iff (!rstN)
    outHashHit |-> outMulticast); // R4

  AST_QUIET_WHEN_INVALID: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!outAccept && outStatusFlags == 32'h0)); // R7

endmodule

bind rx_dest_filter rx_dest_filter_chk u_chk (.*);

// File: tb/rx_dest_filter_bench.sv
`timescale 1ns/1ps
module rx_dest_filter_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [47:0] station = 48'h0211_2233_4455;
  logic [63:0] hmask = 64'h0;
  logic [1:0]  mode = 2'b00;
  logic        inSof = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  inByte = 8'h00;
  logic        outValid, outAccept, outMulticast, outBroadcast;
  logic        outStationHit, outHashHit;
  logic [31:0] outStatusFlags;

  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  rx_dest_filter u_rx_dest_filter (
    .clk(clk), .rstN(rstN), .cfgStation(station), .cfgHashMask(hmask),
    .cfgMode(mode), .inSof(inSof), .inValid(inValid), .inByte(inByte),
    .outValid(outValid), .outAccept(outAccept), .outMulticast(outMulticast),
    .outBroadcast(outBroadcast), .outStationHit(outStationHit),
    .outHashHit(outHashHit), .outStatusFlags(outStatusFlags)
  );

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic logic [47:0] rndAddr();
    logic [31:0] a = rnd();
    logic [31:0] b = rnd();
    return {a[15:0], b};
  endfunction

  // Reference hash index per R4
  function automatic logic [5:0] refIdx(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++) begin
      logic [7:0] b = a[47-8*i -: 8];
      for (int j = 0; j < 8; j++) begin
        if (c[31] != b[j]) c = (c << 1) ^ 32'h04C1_1DB7;
        else               c = c << 1;
      end
    end
    return c[31:26];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input logic acc, mc, bc, sh, hh);
    logic [31:0] w = 32'h0;
    w[19] = mc; w[20] = bc; w[25] = hh; w[26] = sh;
    chk("R7 valid after second edge", {31'h0, outValid}, 32'h1);
    chk("R5 accept", {31'h0, outAccept}, {31'h0, acc});
    chk("R3 multicast", {31'h0, outMulticast}, {31'h0, mc});
    chk("R3 broadcast", {31'h0, outBroadcast}, {31'h0, bc});
    chk("R2 station hit", {31'h0, outStationHit}, {31'h0, sh});
    chk("R4 hash hit", {31'h0, outHashHit}, {31'h0, hh});
    chk("R10 status word", outStatusFlags, w);
  endtask

  // Sends one address; optional idle gaps, trailing payload and a mid-frame
  // configuration swap (applied before the fourth byte is taken).
  task automatic runFrame(input logic [47:0] a, input bit gaps, input bit trail,
                          input bit swap, input logic [1:0] m2,
                          input logic [47:0] s2, input logic [63:0] h2);
    logic [1:0]  em = mode;
    logic [47:0] es = station;
    logic [63:0] eh = hmask;
    logic mc, bc, sh, hh, acc;
    mc  = a[40];
    bc  = (a == 48'hFFFF_FFFF_FFFF);
    sh  = (a == es);
    hh  = mc & eh[refIdx(a)];
    acc = (em == 2'b11) | bc | sh | ((em == 2'b10) & mc) | ((em == 2'b01) & hh);
    for (int i = 0; i < 6; i++) begin
      if (gaps && i != 0) begin
        logic [31:0] r = rnd();
        @(negedge clk);
        inValid = 1'b0; inSof = r[0]; inByte = r[15:8];
      end
      @(negedge clk);
      inValid = 1'b1; inSof = (i == 0); inByte = a[47-8*i -: 8];
      if (swap && i == 3) begin
        mode = m2; station = s2; hmask = h2;
      end
    end
    @(negedge clk);
    inValid = 1'b0; inSof = 1'b0;
    chk("R7 not valid after first edge", {31'h0, outValid}, 32'h0);
    @(negedge clk);
    checkAll(acc, mc, bc, sh, hh);
    if (trail) begin
      for (int i = 0; i < 5; i++) begin
        logic [31:0] r = rnd();
        @(negedge clk);
        inValid = 1'b1; inSof = 1'b0; inByte = r[7:0];
      end
      @(negedge clk);
      inValid = 1'b0;
      @(negedge clk);
      chk("R8 trailing bytes ignored", {31'h0, outAccept}, {31'h0, acc});
      checkAll(acc, mc, bc, sh, hh);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset valid", {31'h0, outValid}, 32'h0);
    chk("R1 reset accept", {31'h0, outAccept}, 32'h0);
    chk("R1 reset flags", outStatusFlags, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release", {31'h0, outValid}, 32'h0);

    // R8: bytes before the first start byte are ignored
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      inValid = 1'b1; inSof = 1'b0; inByte = 8'hFF;
    end
    @(negedge clk);
    inValid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 no frame without start", {31'h0, outValid}, 32'h0);

    // Mode x mask sweep
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 3; k++) begin
        logic [31:0] r1 = rnd();
        logic [31:0] r2 = rnd();
        mode  = m[1:0];
        hmask = (k == 0) ? 64'h0 : (k == 1) ? 64'hFFFF_FFFF_FFFF_FFFF : {r1, r2};
        runFrame(station, n[0], n[1], 1'b0, 2'b0, 48'h0, 64'h0); n++;
        chk("R6 station accepted", {31'h0, outAccept}, 32'h1);
        runFrame(48'hFFFF_FFFF_FFFF, n[0], n[1], 1'b0, 2'b0, 48'h0, 64'h0); n++;
        chk("R6 broadcast accepted", {31'h0, outAccept}, 32'h1);
        runFrame(station ^ 48'h1, n[0], n[1], 1'b0, 2'b0, 48'h0, 64'h0); n++;
        for (int f = 0; f < 12; f++) begin
          runFrame(rndAddr(), n[0], n[1], 1'b0, 2'b0, 48'h0, 64'h0); n++;
        end
      end
    end

    // Hash index sweep, mode 01, one mask bit at a time
    mode = 2'b01;
    for (int idx = 0; idx < 64; idx++) begin
      logic [47:0] hit, miss;
      hmask = 64'h1 << idx;
      do begin hit = rndAddr(); hit[40] = 1'b1; end while (refIdx(hit) != idx[5:0] || hit == station);
      do begin miss = rndAddr(); miss[40] = 1'b1; end while (refIdx(miss) == idx[5:0] || miss == station || miss == 48'hFFFF_FFFF_FFFF);
      runFrame(hit, idx[0], 1'b0, 1'b0, 2'b0, 48'h0, 64'h0);
      chk("R4 index selects mask bit", {31'h0, outHashHit}, 32'h1);
      runFrame(miss, idx[1], 1'b0, 1'b0, 2'b0, 48'h0, 64'h0);
      chk("R4 other index misses", {31'h0, outAccept}, 32'h0);
    end

    // R9: configuration changes inside a frame take effect next frame
    begin
      logic [47:0] mcA = 48'h0133_5577_99BB;
      mode = 2'b00; hmask = 64'h0;
      runFrame(mcA, 1'b0, 1'b0, 1'b1, 2'b11, station, 64'h0);
      chk("R9 old mode kept", {31'h0, outAccept}, 32'h0);
      runFrame(mcA, 1'b0, 1'b0, 1'b0, 2'b0, 48'h0, 64'h0);
      chk("R9 new mode used", {31'h0, outAccept}, 32'h1);
      mode = 2'b00;
      runFrame(48'h0A0B_0C0D_0E0F, 1'b0, 1'b0, 1'b1, 2'b00, 48'h0A0B_0C0D_0E0F, 64'h0);
      chk("R9 old station kept", {31'h0, outStationHit}, 32'h0);
      runFrame(48'h0A0B_0C0D_0E0F, 1'b1, 1'b1, 1'b0, 2'b0, 48'h0, 64'h0);
      chk("R9 new station used", {31'h0, outStationHit}, 32'h1);
    end

    // R7: a new start byte clears the held decision
    @(negedge clk);
    inValid = 1'b1; inSof = 1'b1; inByte = 8'h00;
    @(negedge clk);
    inValid = 1'b0; inSof = 1'b0;
    chk("R7 start clears decision", {31'h0, outValid}, 32'h0);
    chk("R7 start clears flags", outStatusFlags, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule